// File: doc/BRIEF.md
# Motion Activity and Inactivity Detector

This block watches a stream of three-axis acceleration samples and decides when the sensor has started moving and when it has come to rest. Every strobed sample is compared per axis against a programmable activity threshold and a programmable inactivity threshold. A detector only reports an event when its condition has lasted for a programmable time. The block keeps an awake state that is set by activity and cleared by inactivity. It drives two interrupt request lines, and a map register chooses the sources for each line.

The time codes are counted in clock cycles. One time code lasts `ACT_UNIT` (activity) or `INACT_UNIT` (inactivity) cycles at the fastest output data rate. It lasts twice as long at every slower rate. The comparison on each axis can use the raw sample, or it can use the sample taken relative to a reference. The reference is the sample that was current when the opposite event last fired.

The two detectors can run independently. In the chained modes they take turns: while the block is asleep only the activity detector is armed, and while it is awake only the inactivity detector is armed. In linked mode each event also waits for a host acknowledge before the next event can fire. Configuration is written through a simple byte-wide write port.

Top module: `motion_watch`

## Requirements
- R1: After synchronous reset the block is asleep (`awake`=0), both event pulses are 0, both interrupt lines are 0, and every threshold, time, mode and map register is zero.
- R2: Threshold registers use a byte pair per axis, laid out as follows:
  - Addresses: activity X/Y/Z at 0x00/0x02/0x04 and inactivity X/Y/Z at 0x08/0x0A/0x0C hold the high byte. The address plus one holds the low byte.
  - High byte: bits 10:3 of an 11-bit code.
  - Low byte: bits 7:5 hold code bits 2:0, bit 1 is the reference flag and bit 0 is the axis enable.
  - A write takes effect at the next clock edge.
- R3: The activity condition holds when any enabled axis has a magnitude strictly greater than its activity code. A magnitude equal to the code does not count. Negative samples count by their absolute value.
- R4: The activity time code is 8 bits (address 0x10). The inactivity time code is 16 bits (high byte 0x11, low byte 0x12). One code lasts `ACT_UNIT` or `INACT_UNIT` cycles when `odr_sel`=4 and twice as many cycles for any other `odr_sel`. An event pulse appears N*L+1 edges after the sample edge that starts the condition, where N is the code and L is the unit length.
- R5: The inactivity condition holds when every enabled axis has a magnitude strictly below its inactivity code and at least one axis is enabled. Disabled axes are ignored.
- R6: An event is a single one-cycle pulse per persisting condition. A sample that breaks the condition restarts the timer from zero.
- R7: `awake` is set by an activity event and cleared by an inactivity event, in the same cycle as the pulse.
- R8: With the reference flag set, an axis magnitude is |sample − reference|. The reference is the sample that was current when the opposite event last fired, and it is zero after reset.
- R9: The mode field is bits 1:0 at address 0x14, with these codes:
  - 0 (and 3): both detectors run independently of `awake`.
  - 1: linked.
  - 2: looped.
  - In modes 1 and 2, only activity is armed while asleep and only inactivity is armed while awake.
- R10: In linked mode, no event fires after an event until `ack` is pulsed. The next event can then appear one edge after the acknowledge edge. Looped mode re-arms without `ack`.
- R11: Map registers at 0x15 (line A) and 0x16 (line B) use these bits:
  - Bit 4 routes the latched inactivity flag.
  - Bit 5 routes the latched activity flag.
  - Bit 6 routes `awake`.
  - Bit 7 makes the line active-low.
  - The flags set with their event and clear on `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe: the three samples are new this cycle |
| smp_x | input | 12 | X sample, two's complement |
| smp_y | input | 12 | Y sample, two's complement |
| smp_z | input | 12 | Z sample, two's complement |
| odr_sel | input | 3 | Output data rate code, 4 is the fastest rate |
| cfg_wr | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration register address |
| cfg_data | input | 8 | Configuration write data |
| ack | input | 1 | Host acknowledge: clears the flags and releases the linked hold |
| act_evt | output | 1 | One-cycle activity event |
| inact_evt | output | 1 | One-cycle inactivity event |
| awake | output | 1 | Awake state |
| irq_a | output | 1 | Interrupt request line A |
| irq_b | output | 1 | Interrupt request line B |

## Verification
Every result is due at a fixed edge. An event pulse, `awake`, the latched flags and the interrupt lines all change at edge N*L+1 after the edge that takes the qualifying sample. A configuration write acts at its own edge. An `ack` clears the flags at its edge, and a linked detector it releases can fire one edge later. The bench drives on falling edges and counts the rising edges since the stimulus. For each timed event it checks that the output is still low one edge before the due edge and high at the due edge. For windows that must stay quiet it uses a pulse counter sampled on rising edges.

// File: rtl/motion_watch_pkg.sv
package motion_watch_pkg;

    localparam int AXES     = 3;
    localparam int SMP_W    = 12;
    localparam int THR_W    = 11;
    localparam int ADDR_W   = 5;
    localparam int MAG_W    = SMP_W + 1;
    localparam logic [2:0] ODR_FASTEST = 3'd4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_ACT_TIME  = 5'h10;
    localparam logic [ADDR_W-1:0] A_INACT_HI  = 5'h11;
    localparam logic [ADDR_W-1:0] A_INACT_LO  = 5'h12;
    localparam logic [ADDR_W-1:0] A_MODE      = 5'h14;
    localparam logic [ADDR_W-1:0] A_MAP_A     = 5'h15;
    localparam logic [ADDR_W-1:0] A_MAP_B     = 5'h16;

    typedef enum logic [1:0] {
        PM_INDEP  = 2'd0,
        PM_LINKED = 2'd1,
        PM_LOOPED = 2'd2,
        PM_SPARE  = 2'd3
    } proc_mode_e;

    typedef struct packed {
        logic [THR_W-1:0] code;
        logic             ref_en;
        logic             en;
    } axis_thr_t;

    typedef logic [AXES-1:0][SMP_W-1:0] axes_t;

    // magnitude of a sample, optionally relative to a reference
    function automatic logic [MAG_W-1:0] axis_mag(input logic [SMP_W-1:0] s,
                                                   input logic [SMP_W-1:0] r,
                                                   input logic use_ref);
        logic signed [MAG_W-1:0] d;
        d = use_ref ? ($signed({s[SMP_W-1], s}) - $signed({r[SMP_W-1], r}))
                    : $signed({s[SMP_W-1], s});
        return d[MAG_W-1] ? MAG_W'(-d) : MAG_W'(d);
    endfunction

endpackage

// File: rtl/motion_watch_regs.sv
module motion_watch_regs
    import motion_watch_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    output axis_thr_t [AXES-1:0]  act_thr,
    output axis_thr_t [AXES-1:0]  inact_thr,
    output logic [7:0]            act_time,
    output logic [15:0]           inact_time,
    output proc_mode_e            mode,
    output logic [7:0]            map_a,
    output logic [7:0]            map_b
);
    localparam int NBYTES = 2 * AXES;

    logic [7:0] act_raw   [NBYTES];
    logic [7:0] inact_raw [NBYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) begin
                act_raw[i]   <= '0;
                inact_raw[i] <= '0;
            end
            act_time   <= '0;
            inact_time <= '0;
            mode       <= PM_INDEP;
            map_a      <= '0;
            map_b      <= '0;
        end else if (wr_en) begin
            if (wr_addr[4:3] == 2'b00 && int'(wr_addr[2:0]) < NBYTES)
                act_raw[wr_addr[2:0]] <= wr_data;
            if (wr_addr[4:3] == 2'b01 && int'(wr_addr[2:0]) < NBYTES)
                inact_raw[wr_addr[2:0]] <= wr_data;
            case (wr_addr)
                A_ACT_TIME: act_time         <= wr_data;
                A_INACT_HI: inact_time[15:8] <= wr_data;
                A_INACT_LO: inact_time[7:0]  <= wr_data;
                A_MODE:     mode             <= proc_mode_e'(wr_data[1:0]);
                A_MAP_A:    map_a            <= wr_data;
                A_MAP_B:    map_b            <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar a = 0; a < AXES; a++) begin : g_decode
        assign act_thr[a]   = {act_raw[2*a],   act_raw[2*a+1][7:5],
                               act_raw[2*a+1][1],   act_raw[2*a+1][0]};
        assign inact_thr[a] = {inact_raw[2*a], inact_raw[2*a+1][7:5],
                               inact_raw[2*a+1][1], inact_raw[2*a+1][0]};
    end

endmodule

// File: rtl/motion_watch_cmp.sv
module motion_watch_cmp
    import motion_watch_pkg::*;
#(
    parameter bit DETECT_ACT = 1'b1
) (
    input  axes_t                 sample,
    input  axes_t                 ref_s,
    input  axis_thr_t [AXES-1:0]  thr,
    output logic                  hit
);
    logic [AXES-1:0] en_v;
    logic [AXES-1:0] ok_v;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        logic [MAG_W-1:0] mag;
        assign mag     = axis_mag(sample[a], ref_s[a], thr[a].ref_en);
        assign en_v[a] = thr[a].en;
        if (DETECT_ACT) begin : g_over
            assign ok_v[a] = thr[a].en && (mag > {2'b00, thr[a].code});
        end else begin : g_under
            assign ok_v[a] = !thr[a].en || (mag < {2'b00, thr[a].code});
        end
    end

    if (DETECT_ACT) begin : g_any
        assign hit = |ok_v;
    end else begin : g_all
        assign hit = (&ok_v) && (|en_v);
    end

endmodule

// File: rtl/motion_watch_timer.sv
module motion_watch_timer #(
    parameter int CODE_W    = 8,
    parameter int UNIT_BASE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              hit,
    input  logic              allow,
    input  logic              fast,
    input  logic [CODE_W-1:0] code,
    output logic              fire
);
    localparam int PRE_W = (2 * UNIT_BASE > 1) ? $clog2(2 * UNIT_BASE) : 1;

    logic              hit_q;
    logic              done_q;
    logic [PRE_W-1:0]  pre_q;
    logic [CODE_W-1:0] units_q;
    logic [PRE_W-1:0]  unit_last;

    assign unit_last = fast ? PRE_W'(UNIT_BASE - 1) : PRE_W'(2 * UNIT_BASE - 1);
    assign fire      = allow && hit_q && !done_q && (units_q >= code);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            done_q  <= 1'b0;
            pre_q   <= '0;
            units_q <= '0;
        end else begin
            if (strobe)
                hit_q <= hit;
            if (!allow || (strobe && !hit)) begin
                pre_q   <= '0;
                units_q <= '0;
                done_q  <= 1'b0;
            end else if (fire) begin
                done_q <= 1'b1;
            end else if (hit_q && !done_q && units_q < code) begin
                if (pre_q >= unit_last) begin
                    pre_q   <= '0;
                    units_q <= units_q + CODE_W'(1);
                end else begin
                    pre_q <= pre_q + PRE_W'(1);
                end
            end
        end
    end

    // an event is exactly one cycle long
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/motion_watch.sv
module motion_watch
    import motion_watch_pkg::*;
#(
    parameter int ACT_UNIT   = 2,
    parameter int INACT_UNIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_valid,
    input  logic [11:0] smp_x,
    input  logic [11:0] smp_y,
    input  logic [11:0] smp_z,
    input  logic [2:0]  odr_sel,
    input  logic        cfg_wr,
    input  logic [4:0]  cfg_addr,
    input  logic [7:0]  cfg_data,
    input  logic        ack,
    output logic        act_evt,
    output logic        inact_evt,
    output logic        awake,
    output logic        irq_a,
    output logic        irq_b
);
    axis_thr_t [AXES-1:0] act_thr, inact_thr;
    logic [7:0]           act_time, map_a, map_b;
    logic [15:0]          inact_time;
    proc_mode_e           mode;

    axes_t smp_now, cur_q, ref_act, ref_inact;
    logic  act_hit, inact_hit, act_fire, inact_fire;
    logic  act_allow, inact_allow, chained, fast;
    logic  hold_q, act_flag, inact_flag;

    assign smp_now     = {smp_z, smp_y, smp_x};
    assign fast        = (odr_sel == ODR_FASTEST);
    assign chained     = (mode == PM_LINKED) || (mode == PM_LOOPED);
    assign act_allow   = !chained || (!awake && !hold_q);
    assign inact_allow = !chained || (awake && !hold_q);

    motion_watch_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_data),
        .act_thr(act_thr), .inact_thr(inact_thr), .act_time(act_time),
        .inact_time(inact_time), .mode(mode), .map_a(map_a), .map_b(map_b)
    );

    motion_watch_cmp #(.DETECT_ACT(1'b1)) u_act_cmp (
        .sample(smp_now), .ref_s(ref_act), .thr(act_thr), .hit(act_hit)
    );

    motion_watch_cmp #(.DETECT_ACT(1'b0)) u_inact_cmp (
        .sample(smp_now), .ref_s(ref_inact), .thr(inact_thr), .hit(inact_hit)
    );

    motion_watch_timer #(.CODE_W(8), .UNIT_BASE(ACT_UNIT)) u_act_tmr (
        .clk(clk), .rst(rst), .strobe(smp_valid), .hit(act_hit), .allow(act_allow),
        .fast(fast), .code(act_time), .fire(act_fire)
    );

    motion_watch_timer #(.CODE_W(16), .UNIT_BASE(INACT_UNIT)) u_inact_tmr (
        .clk(clk), .rst(rst), .strobe(smp_valid), .hit(inact_hit), .allow(inact_allow),
        .fast(fast), .code(inact_time), .fire(inact_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            ref_act    <= '0;
            ref_inact  <= '0;
            act_evt    <= 1'b0;
            inact_evt  <= 1'b0;
            awake      <= 1'b0;
            act_flag   <= 1'b0;
            inact_flag <= 1'b0;
            hold_q     <= 1'b0;
        end else begin
            if (smp_valid)
                cur_q <= smp_now;
            act_evt   <= act_fire;
            inact_evt <= inact_fire;
            if (act_fire)
                awake <= 1'b1;
            else if (inact_fire)
                awake <= 1'b0;
            if (act_fire)
                ref_inact <= cur_q;
            if (inact_fire)
                ref_act <= cur_q;
            act_flag   <= act_fire   || (act_flag   && !ack);
            inact_flag <= inact_fire || (inact_flag && !ack);
            hold_q     <= (mode == PM_LINKED) && (act_fire || inact_fire || (hold_q && !ack));
        end
    end

    assign irq_a = map_a[7] ^ |(map_a[6:4] & {awake, act_flag, inact_flag});
    assign irq_b = map_b[7] ^ |(map_b[6:4] & {awake, act_flag, inact_flag});

    assert_awake_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(awake) |-> act_evt);

    assert_awake_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(awake) |-> inact_evt);

    assert_chain_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        (chained && $stable(mode)) |-> $onehot0({act_evt, inact_evt}));

    assert_linked_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_LINKED && hold_q && !ack) |=> (!act_evt && !inact_evt));

endmodule

// File: tb/test_motion_watch.sv
`timescale 1ns/1ps
module test_motion_watch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] sx = '0, sy = '0, sz = '0;
    logic [2:0]  odr = 3'd4;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_data = '0;
    logic        ack = 1'b0;
    logic        act_evt, inact_evt, awake, irq_a, irq_b;

    int checks = 0, errors = 0, act_cnt = 0, inact_cnt = 0;

    always #5 clk = ~clk;

    motion_watch i_motion_watch (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(sx), .smp_y(sy), .smp_z(sz),
        .odr_sel(odr), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .ack(ack), .act_evt(act_evt), .inact_evt(inact_evt), .awake(awake),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always @(posedge clk) begin
        if (act_evt)   act_cnt++;
        if (inact_evt) inact_cnt++;
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic [11:0] x, input logic [11:0] y, input logic [11:0] z);
        sx = x; sy = y; sz = z; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // event due k edges after the sample edge: low one edge before, high at k
    task automatic expect_evt(input bit inact, input int k, input string req);
        wait_n(k - 1);
        chk(req, "event early", inact ? int'(inact_evt) : int'(act_evt), 0);
        wait_n(1);
        chk(req, "event due", inact ? int'(inact_evt) : int'(act_evt), 1);
    endtask

    task automatic reset_dut();
        rst = 1'b1; smp_valid = 1'b0; cfg_wr = 1'b0; ack = 1'b0; odr = 3'd4;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
    endtask

    task automatic t_reset();
        reset_dut();
        chk("R1", "awake", awake, 0);
        chk("R1", "act_evt", act_evt, 0);
        chk("R1", "inact_evt", inact_evt, 0);
        chk("R1", "irq_a", irq_a, 0);
        chk("R1", "irq_b", irq_b, 0);
    endtask

    task automatic t_act_basic();
        int c0;
        wr(5'h00, 8'h01); wr(5'h01, 8'h41);   // X code 10, enabled (R2)
        wr(5'h10, 8'd3);
        c0 = act_cnt;
        send(12'd10, 0, 0);                   // equal is not above (R3)
        wait_n(12);
        chk("R3", "no event at threshold", act_cnt - c0, 0);
        send(12'd11, 0, 0);
        expect_evt(0, 7, "R2");
        chk("R7", "awake after activity", awake, 1);
        wait_n(10);
        chk("R6", "single pulse", act_cnt - c0, 1);
    endtask

    task automatic t_act_slow_rate();
        send(0, 0, 0);
        odr = 3'd1;
        send(12'hFEC, 0, 0);                  // -20, slow rate doubles unit
        expect_evt(0, 13, "R4");
        chk("R9", "independent mode fires while awake", awake, 1);
        odr = 3'd4;
    endtask

    task automatic t_act_restart();
        int c0;
        send(0, 0, 0);
        c0 = act_cnt;
        send(12'd20, 0, 0);
        wait_n(4);
        send(0, 0, 0);
        send(12'd20, 0, 0);
        expect_evt(0, 7, "R6");
        wait_n(3);
        chk("R6", "restart gives one event", act_cnt - c0, 1);
    endtask

    task automatic t_inact();
        int c0;
        wr(5'h08, 8'h00); wr(5'h09, 8'hA1);   // X inactivity code 5
        wr(5'h0A, 8'h00); wr(5'h0B, 8'hA1);   // Y inactivity code 5
        wr(5'h11, 8'h00); wr(5'h12, 8'h02);
        c0 = inact_cnt;
        send(12'd2, 12'd5, 12'd2000);
        wait_n(25);
        chk("R5", "equal is not below", inact_cnt - c0, 0);
        send(12'd2, 12'hFFD, 12'd2000);       // z disabled, ignored
        expect_evt(1, 7, "R5");
        chk("R7", "asleep after inactivity", awake, 0);
    endtask

    task automatic t_inact_long();
        send(12'd50, 0, 0);
        wait_n(8);
        chk("R7", "awake again", awake, 1);
        wr(5'h11, 8'h01); wr(5'h12, 8'h00);   // 256 codes
        send(0, 0, 0);
        expect_evt(1, 769, "R4");
    endtask

    task automatic t_linked();
        int c0;
        reset_dut();
        wr(5'h00, 8'h01); wr(5'h01, 8'h41);
        wr(5'h08, 8'h00); wr(5'h09, 8'hA1);
        wr(5'h14, 8'h01);
        wr(5'h15, 8'h30); wr(5'h16, 8'hC0);
        chk("R11", "active-low idle line", irq_b, 1);
        send(12'd50, 0, 0);
        expect_evt(0, 1, "R9");
        chk("R11", "line A on activity flag", irq_a, 1);
        chk("R11", "line B awake active-low", irq_b, 0);
        c0 = inact_cnt;
        send(0, 0, 0);
        wait_n(10);
        chk("R10", "linked holds until ack", inact_cnt - c0, 0);
        chk("R10", "still awake", awake, 1);
        pulse_ack();
        chk("R11", "ack clears flag", irq_a, 0);
        chk("R10", "no event at ack edge", inact_evt, 0);
        wait_n(1);
        chk("R10", "event after ack", inact_evt, 1);
        chk("R7", "asleep", awake, 0);
        chk("R11", "line A on inactivity flag", irq_a, 1);
        chk("R11", "line B asleep", irq_b, 1);
    endtask

    task automatic t_looped();
        wr(5'h14, 8'h02);
        send(12'd50, 0, 0);
        expect_evt(0, 1, "R9");
        send(0, 0, 0);
        expect_evt(1, 1, "R10");
        chk("R10", "looped asleep without ack", awake, 0);
    endtask

    task automatic t_referenced();
        int c0;
        reset_dut();
        wr(5'h00, 8'h01); wr(5'h01, 8'h43);   // X code 10, referenced
        wr(5'h08, 8'h00); wr(5'h09, 8'hA1);
        send(12'd100, 0, 0);
        expect_evt(0, 1, "R8");
        send(12'd3, 0, 0);
        expect_evt(1, 1, "R8");
        c0 = act_cnt;
        send(12'd12, 0, 0);                   // |12-3| = 9
        wait_n(6);
        chk("R8", "relative below threshold", act_cnt - c0, 0);
        send(12'd14, 0, 0);                   // |14-3| = 11
        expect_evt(0, 1, "R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_act_basic();
        t_act_slow_rate();
        t_act_restart();
        t_inact();
        t_inact_long();
        t_linked();
        t_looped();
        t_referenced();
        finish_run();
    end

endmodule